// File: doc/BRIEF.md
# DMA Channel Handshake and Terminal Count

This block runs the per-channel handshake of an ISA-style DMA controller that has seven channels, numbered 0 to 3 and 5 to 6 to 7. Slot 4 does not exist. Request lines arrive asynchronously and pass through a synchronizer. Each level is then corrected for its programmed polarity and qualified over two samples, so that a request which vanishes early is never granted. A fixed-priority arbiter selects a channel between transfer cycles and drives one acknowledge line. The acknowledge line also has a programmable polarity. The same acknowledge serves as the bus-release point when an external bus master uses the channel in cascade.

A transfer sequencer outside the block supplies two signals. The first is the address-enable phase indicator. The second is a strobe, pulsed each time a new address is placed on the bus for the granted channel. The block keeps a current and a base byte count for each channel. When a strobe finds the current count at zero, the count expires and the terminal-count output is raised. In normal mode that output stays high until the address-enable phase ends, and the channel is released at that point. In auto-initialize mode the output lasts one cycle, the base count is restored, and the channel keeps its grant.

Top module: `dma_hs_ctrl`

## Requirements
- R1: Slot 4 is never acknowledged, whatever level its request pin carries. Its acknowledge line always stays at the inactive level.
- R2: When `req_act_lo` is 0, a request is active on a high pin. When it is 1, a request is active on a low pin.
- R3: When `ack_act_hi` is 1, the acknowledged line is driven high and all other lines low. When it is 0, the levels are inverted. A change of this input shows at the next clock edge.
- R4: A request that is active at two consecutive clock edges k and k+1, while the block is idle and `aen` is low, is acknowledged at the pins after edge k+2 and not earlier.
- R5: A request that is active at only one sampling edge is never acknowledged.
- R6: When several requests are pending at the grant decision, the channel with the lowest number is acknowledged.
- R7: At most one acknowledge is active at a time. A granted channel keeps its acknowledge while `aen` is high or while its request stays active, even if a higher-priority channel starts requesting. If its request drops while `aen` is low, the acknowledge is removed at the second edge after the drop. The next grant follows at the edge after that.
- R8: After a count of N is loaded for a channel, the (N+1)-th accepted `adr_stb` makes the count expire. `tc` is high in the cycle after that strobe edge. Strobes are accepted only while a channel is granted and `aen` is high.
- R9: In normal mode (`autoinit` = 0 at expiry), `tc` stays high while `aen` stays high. At the first edge that samples `aen` low, `tc` falls and the acknowledge is removed, even if the request is still active.
- R10: In auto-initialize mode (`autoinit` = 1 at expiry), `tc` is high for exactly one cycle while `aen` stays high. The acknowledge is kept, and the count is reloaded from the base value, so the next expiry comes after another N+1 strobes.
- R11: While `rst` is high and at the first edge after it, all acknowledge lines are high and `tc` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_line | input | NCH | Asynchronous request pins, one per slot |
| req_act_lo | input | 1 | Request polarity: 1 means active low |
| ack_act_hi | input | 1 | Acknowledge polarity: 1 means active high |
| aen | input | 1 | Address-enable phase from the transfer sequencer |
| adr_stb | input | 1 | New address placed on the bus for the granted channel |
| autoinit | input | 1 | Auto-initialize mode for the current expiry |
| cnt_wr | input | 1 | Load strobe for a channel's base and current count |
| cnt_ch | input | CH_W | Channel selected for the load |
| cnt_val | input | CNT_W | Count value to load |
| ack_line | output | NCH | Acknowledge pins, registered |
| tc | output | 1 | Terminal-count indicator |

## Verification
The arbiter is swept over every subset of the seven real channels. In half of the subsets a stray level is also placed on slot 4. The whole sweep runs once with active-high requests and active-low acknowledges, then again with both polarities inverted. This separates a wrong priority order, a leak from slot 4, and a polarity error on either side, and it also tests the exact edge at which the acknowledge appears. Single-sample pulses and a higher-priority request that arrives during a held grant separate glitch filtering from preemption. The count is tried with loads from 0 to 7 in normal mode and with several loads in auto-initialize mode over two rounds. These runs expose off-by-one expiry, a wrong terminal-count length and a missing reload. In normal mode the release after terminal count is also tried with the request withdrawn and with it still held.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  // Phase of the terminal-count output
  typedef enum logic [1:0] {
    TC_OFF   = 2'd0,
    TC_HOLD  = 2'd1,   // normal completion: held until address enable ends
    TC_PULSE = 2'd2    // auto-initialize: single cycle
  } tc_phase_e;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int NCH     = 8,
  parameter int HOLE    = 4,
  parameter int SYNC_ST = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_line,
  input  logic           req_act_lo,
  output logic [NCH-1:0] pend
);

  localparam logic [NCH-1:0] HOLE_MASK = NCH'(1) << HOLE;

  logic [NCH-1:0] qual;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SYNC_ST-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SYNC_ST-2:0], req_line[i] ^ req_act_lo};
    end
    // active on the two most recent samples
    assign qual[i] = sh[SYNC_ST-1] & sh[SYNC_ST-2];
  end

  assign pend = qual & ~HOLE_MASK;

endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]  pend,
  output logic [NCH-1:0]  oh,
  output logic [CH_W-1:0] idx,
  output logic            any
);

  always_comb begin
    oh  = '0;
    idx = '0;
    any = |pend;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        oh    = '0;
        oh[i] = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end

endmodule

// File: rtl/dma_tc_cnt.sv
module dma_tc_cnt
  import dma_hs_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CNT_W = 8,
  parameter int CH_W  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CH_W-1:0]  ld_ch,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             stb,
  input  logic [CH_W-1:0]  ch,
  input  logic             ai,
  input  logic             aen,
  output logic             tc,
  output logic             tc_hold,
  output logic             tc_pulse
);

  logic [CNT_W-1:0] cur_mem  [NCH];
  logic [CNT_W-1:0] base_mem [NCH];
  tc_phase_e        st;

  logic [CNT_W-1:0] cur_rd;
  logic             expire;

  assign cur_rd = cur_mem[ch];
  assign expire = stb & (cur_rd == '0);

  // count storage, no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (stb) begin
      if (expire && ai) cur_mem[ch] <= base_mem[ch];
      else              cur_mem[ch] <= cur_rd - 1'b1;
    end
    if (ld) begin
      cur_mem[ld_ch]  <= ld_val;
      base_mem[ld_ch] <= ld_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TC_OFF;
    end else begin
      unique case (st)
        TC_HOLD:  if (!aen) st <= TC_OFF;
        default:  st <= expire ? (ai ? TC_PULSE : TC_HOLD) : TC_OFF;
      endcase
    end
  end

  assign tc       = (st != TC_OFF);
  assign tc_hold  = (st == TC_HOLD);
  assign tc_pulse = (st == TC_PULSE);

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int HOLE    = 4,
  parameter int CNT_W   = 8,
  parameter int SYNC_ST = 2,
  localparam int CH_W   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   req_line,
  input  logic             req_act_lo,
  input  logic             ack_act_hi,
  input  logic             aen,
  input  logic             adr_stb,
  input  logic             autoinit,
  input  logic             cnt_wr,
  input  logic [CH_W-1:0]  cnt_ch,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [NCH-1:0]   ack_line,
  output logic             tc
);

  logic [NCH-1:0]  pend;
  logic [NCH-1:0]  pick_oh;
  logic [CH_W-1:0] pick_idx;
  logic            pick_any;

  logic            gnt_vld;
  logic [CH_W-1:0] gnt_ch;
  logic [NCH-1:0]  gnt_oh;

  logic            nxt_vld;
  logic [CH_W-1:0] nxt_ch;
  logic [NCH-1:0]  nxt_oh;

  logic            tc_hold;
  logic            tc_pulse;
  logic            stb;
  logic            rel;
  logic            take;

  dma_req_sync #(.NCH(NCH), .HOLE(HOLE), .SYNC_ST(SYNC_ST)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .req_line   (req_line),
    .req_act_lo (req_act_lo),
    .pend       (pend)
  );

  dma_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .pend (pend),
    .oh   (pick_oh),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  assign stb = adr_stb & gnt_vld & aen;

  dma_tc_cnt #(.NCH(NCH), .CNT_W(CNT_W), .CH_W(CH_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .ld       (cnt_wr),
    .ld_ch    (cnt_ch),
    .ld_val   (cnt_val),
    .stb      (stb),
    .ch       (gnt_ch),
    .ai       (autoinit),
    .aen      (aen),
    .tc       (tc),
    .tc_hold  (tc_hold),
    .tc_pulse (tc_pulse)
  );

  // grant changes only between transfer cycles
  assign rel  = gnt_vld & ~aen & (~pend[gnt_ch] | tc_hold);
  assign take = ~gnt_vld & ~aen & pick_any;

  always_comb begin
    nxt_vld = gnt_vld;
    nxt_ch  = gnt_ch;
    nxt_oh  = gnt_oh;
    if (take) begin
      nxt_vld = 1'b1;
      nxt_ch  = pick_idx;
      nxt_oh  = pick_oh;
    end else if (rel) begin
      nxt_vld = 1'b0;
      nxt_oh  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld  <= 1'b0;
      gnt_ch   <= '0;
      gnt_oh   <= '0;
      ack_line <= '1;
    end else begin
      gnt_vld  <= nxt_vld;
      gnt_ch   <= nxt_ch;
      gnt_oh   <= nxt_oh;
      ack_line <= ack_act_hi ? nxt_oh : ~nxt_oh;
    end
  end

endmodule

// File: rtl/dma_hs_chk.sv
module dma_hs_chk #(
  parameter int NCH  = 8,
  parameter int HOLE = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           aen,
  input logic           tc,
  input logic           tc_hold,
  input logic           tc_pulse,
  input logic           gnt_vld,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] gnt_oh,
  input logic [NCH-1:0] ack_line
);

  AST_RESET_LEVELS: assert property (@(posedge clk) rst |=> (ack_line == '1 && !tc)); // R11

  AST_HOLE_NEVER: assert property (@(posedge clk) disable iff (rst) !gnt_oh[HOLE]); // R1

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt_oh)); // R7

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld && !$past(gnt_vld)) |-> (($past(pend) & gnt_oh) != '0)); // R5

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld && !$past(gnt_vld)) |-> (($past(pend) & (gnt_oh - 1'b1)) == '0)); // R6

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld && aen) |=> (gnt_vld && gnt_oh == $past(gnt_oh))); // R7

  AST_TC_HELD: assert property (@(posedge clk) disable iff (rst)
    (tc_hold && aen) |=> tc); // R9

  AST_TC_ENDS: assert property (@(posedge clk) disable iff (rst)
    (tc_hold && !aen) |=> !tc); // R9

  AST_AI_SHORT: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse && !aen) |=> !tc); // R10

endmodule

bind dma_hs_ctrl dma_hs_chk #(.NCH(NCH), .HOLE(HOLE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .aen      (aen),
  .tc       (tc),
  .tc_hold  (tc_hold),
  .tc_pulse (tc_pulse),
  .gnt_vld  (gnt_vld),
  .pend     (pend),
  .gnt_oh   (gnt_oh),
  .ack_line (ack_line)
);

// File: tb/tb_dma_hs_ctrl.sv
module tb_dma_hs_ctrl;

  localparam int NCH   = 8;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic [NCH-1:0]   req_line;
  logic             req_act_lo;
  logic             ack_act_hi;
  logic             aen;
  logic             adr_stb;
  logic             autoinit;
  logic             cnt_wr;
  logic [2:0]       cnt_ch;
  logic [CNT_W-1:0] cnt_val;
  logic [NCH-1:0]   ack_line;
  logic             tc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_hs_ctrl #(.NCH(NCH), .HOLE(4), .CNT_W(CNT_W), .SYNC_ST(2)) dut (
    .clk(clk), .rst(rst), .req_line(req_line), .req_act_lo(req_act_lo),
    .ack_act_hi(ack_act_hi), .aen(aen), .adr_stb(adr_stb), .autoinit(autoinit),
    .cnt_wr(cnt_wr), .cnt_ch(cnt_ch), .cnt_val(cnt_val),
    .ack_line(ack_line), .tc(tc)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] act_vec();
    return ack_act_hi ? ack_line : ~ack_line;
  endfunction

  function automatic logic [7:0] lowest(input logic [7:0] v);
    logic [7:0] m;
    m = v & 8'hEF;
    for (int i = 0; i < 8; i++) if (m[i]) return 8'(1) << i;
    return 8'h00;
  endfunction

  function automatic logic [7:0] pins(input logic [7:0] act);
    return req_act_lo ? ~act : act;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; req_line = '0; req_act_lo = 1'b0; ack_act_hi = 1'b0;
    aen = 1'b0; adr_stb = 1'b0; autoinit = 1'b0; cnt_wr = 1'b0;
    cnt_ch = '0; cnt_val = '0;
    step(1);
    chk("R11 ack in reset", ack_line, 8'hFF);
    chk("R11 tc in reset", tc, 0);
    step(2);
    rst = 1'b0;
    step(1);
    chk("R11 ack after reset", ack_line, 8'hFF);
    chk("R11 tc after reset", tc, 0);

    // priority sweep over all channel subsets, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      req_act_lo = pol[0];
      ack_act_hi = pol[0];
      req_line   = pins(8'h00);
      step(3);
      for (int m = 0; m < 128; m++) begin
        logic [7:0] act;
        act = {m[6:4], m[1] ^ m[5], m[3:0]};
        req_line = pins(act);
        step(2);
        chk("R4 no ack before third edge", act_vec(), 8'h00);
        step(1);
        chk("R6 R1 R2 R3 lowest channel acknowledged", act_vec(), lowest(act));
        req_line = pins(8'h00);
        step(2);
        chk("R7 released after request drop", act_vec(), 8'h00);
      end
    end
    req_act_lo = 1'b0; ack_act_hi = 1'b0; req_line = '0;
    step(3);

    // short pulse
    for (int c = 0; c < 8; c++) begin
      req_line = 8'(1) << c;
      step(1);
      req_line = '0;
      step(6);
      chk("R5 single-sample request ignored", act_vec(), 8'h00);
    end

    // no preemption, then hand-over
    req_line = 8'h20;
    step(3);
    chk("R7 channel 5 granted", act_vec(), 8'h20);
    req_line = 8'h21;
    step(4);
    chk("R7 no preemption by channel 0", act_vec(), 8'h20);
    req_line = 8'h01;
    step(2);
    chk("R7 gap after release", act_vec(), 8'h00);
    step(1);
    chk("R7 next channel granted", act_vec(), 8'h01);
    req_line = '0;
    step(2);
    chk("R7 idle", act_vec(), 8'h00);

    // normal-mode expiry for loads 0..7
    for (int n = 0; n < 8; n++) begin
      cnt_wr = 1'b1; cnt_ch = 3'd6; cnt_val = CNT_W'(n);
      step(1);
      cnt_wr = 1'b0;
      req_line = 8'h40;
      step(3);
      chk("R8 channel 6 granted", act_vec(), 8'h40);
      aen = 1'b1;
      for (int k = 1; k <= n + 1; k++) begin
        adr_stb = 1'b1;
        step(1);
        adr_stb = 1'b0;
        chk("R8 expiry on strobe N+1", tc, (k == n + 1) ? 1 : 0);
      end
      step(2);
      chk("R9 tc held while aen high", tc, 1);
      if (n % 2 == 0) begin
        req_line = '0;
        step(3);
        chk("R9 tc held after request drop", tc, 1);
        chk("R7 grant held while aen high", act_vec(), 8'h40);
        aen = 1'b0;
        step(1);
        chk("R9 tc falls with aen", tc, 0);
        chk("R9 ack released with aen", act_vec(), 8'h00);
      end else begin
        aen = 1'b0;
        step(1);
        chk("R9 tc falls with aen", tc, 0);
        chk("R9 ack released despite request", act_vec(), 8'h00);
        step(1);
        chk("R9 regrant after release", act_vec(), 8'h40);
        req_line = '0;
        step(2);
        chk("R9 idle", act_vec(), 8'h00);
      end
    end

    // auto-initialize
    for (int j = 0; j < 3; j++) begin
      int n;
      n = (j == 0) ? 0 : (j == 1) ? 2 : 5;
      cnt_wr = 1'b1; cnt_ch = 3'd2; cnt_val = CNT_W'(n);
      step(1);
      cnt_wr = 1'b0;
      autoinit = 1'b1;
      req_line = 8'h04;
      step(3);
      chk("R10 channel 2 granted", act_vec(), 8'h04);
      aen = 1'b1;
      for (int r = 0; r < 2; r++) begin
        for (int k = 1; k <= n + 1; k++) begin
          adr_stb = 1'b1;
          step(1);
          adr_stb = 1'b0;
          chk("R10 R8 expiry after reload", tc, (k == n + 1) ? 1 : 0);
        end
        step(1);
        chk("R10 tc single cycle", tc, 0);
        chk("R10 grant kept", act_vec(), 8'h04);
      end
      aen = 1'b0; autoinit = 1'b0; req_line = '0;
      step(2);
      chk("R10 idle after drop", act_vec(), 8'h00);
    end

    finish_run();
  end

endmodule